// File: doc/BRIEF.md
# Windowed Semaphore Array

The block holds a bank of 32-bit counting semaphores. A bus master picks both the entry and the operation with one byte address. The entry index comes from the low address bits, with one entry every four bytes. The two address bits above the index choose the window: read, set, add or subtract. Every operation that changes a value is therefore a single store, and the block applies the whole read-modify-write within one clock. No bus lock is needed.

The block has a second input, a completion port. A DMA engine pulses this port with a semaphore number when a transfer finishes, and the block adds one to that entry. A transfer that signals two semaphores works as follows:
- The local one is bumped through the completion port.
- The remote peer's one arrives as an ordinary bus store into the add window.

The bus and the completion port may hit the same entry in the same cycle. When they do, both effects land together in that cycle.

Arithmetic never wraps. Subtraction clamps at zero and addition clamps at the all-ones value. Either clamp raises a flag that stays set until reset.

Top module: `sem_window_array`

## Requirements
- R1: After reset every entry reads 0, `sat_err` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The request address is decoded as follows. Bits [9:2] hold the index, bits [11:10] hold the window (0 read, 1 set, 2 add, 3 subtract), and bits [1:0] are ignored. A request with `req_write`=0 is a read from any window. It returns the entry's value as it stood before the accepting edge, with `rsp_valid` high from the next cycle, and it has no side effect.
- R3: A store to the set window writes `req_wdata` into the entry.
- R4: A store to the add window adds `req_wdata`. A sum above 0xFFFFFFFF leaves 0xFFFFFFFF and sets `sat_err`. A sum of exactly 0xFFFFFFFF does not set it.
- R5: A store to the subtract window subtracts `req_wdata`. A result below zero leaves 0 and sets `sat_err`. A result of exactly zero does not set it.
- R6: A store to the read window changes no entry.
- R7: When `cmp_valid` is high in a cycle, entry `cmp_sem` gains 1. If the entry already holds 0xFFFFFFFF it stays there and `sat_err` is set.
- R8: If an accepted store and a completion name the same entry in one cycle, the entry becomes the store's result plus 1, saturating as in R7. A store to the read window counts as leaving the old value.
- R9: A store and a completion on different entries in one cycle both take effect.
- R10: `sat_err` stays 1 once set, until reset.
- R11: Read responses use one slot. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low exactly while `rsp_valid` is high and `rsp_ready` is low. During that stall `rsp_rdata` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for a store, 0 for a read |
| req_addr | input | 12 | Byte address: window and index |
| req_wdata | input | 32 | Store data (value or amount) |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 32 | Read data |
| cmp_valid | input | 1 | Completion increment request, always accepted |
| cmp_sem | input | 8 | Entry to increment on completion |
| sat_err | output | 1 | Sticky saturation flag |

## Verification
A bus store and a completion increment can fall in the same cycle, either on one entry or on two entries. The bench provokes this by holding a store until it is accepted and then raising `cmp_valid` on that exact cycle. It does this with set, add and subtract stores, on the same entry and on a different one, and once at the clamp value. It judges the outcome by reading the entries back and comparing them with a model that applies the store first and the plus-one second.

// File: rtl/sem_win_pkg.sv
package sem_win_pkg;
  typedef enum logic [1:0] {
    WIN_RD  = 2'd0,
    WIN_SET = 2'd1,
    WIN_INC = 2'd2,
    WIN_DEC = 2'd3
  } win_e;
endpackage

// File: rtl/sem_addr_split.sv
module sem_addr_split
  import sem_win_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = IDX_W + 4
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [IDX_W-1:0]  idx
);
  logic unused_lo;
  assign unused_lo = ^addr[1:0];
  assign idx = addr[IDX_W+1:2];
  assign win = win_e'(addr[ADDR_W-1:ADDR_W-2]);
endmodule

// File: rtl/sem_alu.sv
module sem_alu
  import sem_win_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_val,
  input  logic          bus_en,
  input  win_e          win,
  input  logic [DW-1:0] data,
  input  logic          bump,
  output logic [DW-1:0] new_val,
  output logic          sat
);
  localparam logic [DW-1:0] TOP = '1;
  logic [DW:0]   sum;
  logic [DW-1:0] stage;
  logic          sat_bus;

  always_comb begin
    sum     = {1'b0, old_val} + {1'b0, data};
    stage   = old_val;
    sat_bus = 1'b0;
    if (bus_en) begin
      unique case (win)
        WIN_SET: stage = data;
        WIN_INC: begin
          if (sum[DW]) begin
            stage   = TOP;
            sat_bus = 1'b1;
          end else begin
            stage = sum[DW-1:0];
          end
        end
        WIN_DEC: begin
          if (old_val < data) begin
            stage   = '0;
            sat_bus = 1'b1;
          end else begin
            stage = old_val - data;
          end
        end
        default: stage = old_val;
      endcase
    end
    new_val = stage;
    sat     = sat_bus;
    if (bump) begin
      if (stage == TOP) sat = 1'b1;
      else new_val = stage + 1'b1;
    end
  end
endmodule

// File: rtl/sem_store.sv
module sem_store #(
  parameter int N_SEM = 256,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(N_SEM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_a,
  input  logic [IDX_W-1:0] idx_a,
  input  logic [DW-1:0]    val_a,
  input  logic             we_b,
  input  logic [IDX_W-1:0] idx_b,
  input  logic [DW-1:0]    val_b,
  output logic [DW-1:0]    mem_o [N_SEM]
);
  for (genvar i = 0; i < N_SEM; i++) begin : g_ent
    logic hit_a, hit_b;
    assign hit_a = we_a && (idx_a == IDX_W'(i));
    assign hit_b = we_b && (idx_b == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_o[i] <= '0;
      else if (hit_a) mem_o[i] <= val_a;
      else if (hit_b) mem_o[i] <= val_b;
    end
  end
endmodule

// File: rtl/sem_window_array.sv
module sem_window_array
  import sem_win_pkg::*;
#(
  parameter int N_SEM = 256,
  parameter int DW    = 32,
  localparam int IDX_W  = $clog2(N_SEM),
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DW-1:0]     rsp_rdata,
  input  logic              cmp_valid,
  input  logic [IDX_W-1:0]  cmp_sem,
  output logic              sat_err
);
  localparam logic [DW-1:0] TOP = '1;

  win_e             win;
  logic [IDX_W-1:0] bus_idx;
  logic [DW-1:0]    mem [N_SEM];
  logic [DW-1:0]    bus_old, cmp_old, bus_new, cmp_new;
  logic             bus_sat, cmp_sat;
  logic             accept, bus_wr, same;

  sem_addr_split #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_split (
    .addr(req_addr), .win(win), .idx(bus_idx)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign bus_wr    = accept && req_write;
  assign same      = bus_wr && cmp_valid && (cmp_sem == bus_idx);
  assign bus_old   = mem[bus_idx];
  assign cmp_old   = mem[cmp_sem];

  sem_alu #(.DW(DW)) u_alu_bus (
    .old_val(bus_old), .bus_en(bus_wr), .win(win), .data(req_wdata),
    .bump(same), .new_val(bus_new), .sat(bus_sat)
  );

  sem_alu #(.DW(DW)) u_alu_cmp (
    .old_val(cmp_old), .bus_en(1'b0), .win(WIN_RD), .data('0),
    .bump(1'b1), .new_val(cmp_new), .sat(cmp_sat)
  );

  sem_store #(.N_SEM(N_SEM), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we_a(bus_wr), .idx_a(bus_idx), .val_a(bus_new),
    .we_b(cmp_valid && !same), .idx_b(cmp_sem), .val_b(cmp_new),
    .mem_o(mem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      sat_err   <= 1'b0;
    end else begin
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= bus_old;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if ((bus_wr && bus_sat) || (cmp_valid && !same && cmp_sat)) sat_err <= 1'b1;
    end
  end

  // Entry indices of the previous cycle, for the checks below
  logic [IDX_W-1:0] bus_idx_q, cmp_idx_q;
  always_ff @(posedge clk) begin
    bus_idx_q <= bus_idx;
    cmp_idx_q <= cmp_sem;
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sat_err |=> sat_err);

  assert_rd_win_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && win == WIN_RD && !cmp_valid |=> mem[bus_idx_q] == $past(bus_old));

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && win == WIN_SET && !same |=> mem[bus_idx_q] == $past(req_wdata));

  assert_cmp_bump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !same && !(bus_wr && bus_idx == cmp_sem) && cmp_old != TOP
    |=> mem[cmp_idx_q] == $past(cmp_old) + 1'b1);
endmodule

// File: tb/sem_window_array_test.sv
`timescale 1ns/1ps
module sem_window_array_test;
  localparam int N = 256;
  localparam logic [31:0] TOP = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, sat_err;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic        cmp_valid = 1'b0;
  logic [7:0]  cmp_sem = '0;

  always #2.5 clk = ~clk;

  sem_window_array uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cmp_valid(cmp_valid), .cmp_sem(cmp_sem), .sat_err(sat_err)
  );

  int checks = 0, errors = 0;
  logic [31:0] model [N];
  logic        exp_err = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: one response per negedge where the handshake is pending
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R2 unexpected response", rsp_rdata, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_rdata == e, t, rsp_rdata, e);
      end
    end
  end

  function automatic logic [32:0] mdl_bus(input logic [31:0] old, input int win, input logic [31:0] d);
    logic [32:0] s;
    s = {1'b0, old} + {1'b0, d};
    case (win)
      1: return {1'b0, d};
      2: return s[32] ? {1'b1, TOP} : {1'b0, s[31:0]};
      3: return (old < d) ? {1'b1, 32'h0} : {1'b0, old - d};
      default: return {1'b0, old};
    endcase
  endfunction

  function automatic logic [32:0] mdl_bump(input logic [31:0] v);
    return (v == TOP) ? {1'b1, TOP} : {1'b0, v + 32'd1};
  endfunction

  task automatic step(input bit ben, input bit wr, input int win, input int idx, input logic [31:0] d,
                      input bit cen, input int cidx, input string tag);
    logic [32:0] r;
    @(negedge clk);
    if (ben) begin
      req_valid = 1'b1; req_write = wr; req_wdata = d;
      req_addr  = {win[1:0], idx[7:0], 2'b00};
      forever begin
        #1;
        if (req_ready) break;
        @(negedge clk);
      end
    end
    cmp_valid = cen; cmp_sem = cidx[7:0];
    @(posedge clk); #1;
    req_valid = 1'b0; cmp_valid = 1'b0;
    if (ben && !wr) begin
      exp_q.push_back(model[idx]);
      tag_q.push_back(tag);
    end
    if (ben && wr) begin
      r = mdl_bus(model[idx], win, d);
      if (cen && cidx == idx) begin
        exp_err = exp_err | r[32];
        r = mdl_bump(r[31:0]);
      end
      model[idx] = r[31:0];
      exp_err = exp_err | r[32];
    end
    if (cen && !(ben && wr && cidx == idx)) begin
      r = mdl_bump(model[cidx]);
      model[cidx] = r[31:0];
      exp_err = exp_err | r[32];
    end
  endtask

  task automatic rd(input int idx, input int win, input string tag);
    step(1, 0, win, idx, 32'h0, 0, 0, tag);
  endtask
  task automatic wr(input int win, input int idx, input logic [31:0] d);
    step(1, 1, win, idx, d, 0, 0, "");
  endtask
  task automatic drain();
    repeat (4) @(negedge clk);
  endtask
  task automatic do_reset();
    drain();
    rst_n = 1'b0;
    foreach (model[i]) model[i] = 32'h0;
    exp_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    do_reset();
    #1;
    check(sat_err == 1'b0, "R1 sat_err after reset", {31'h0, sat_err}, 32'h0);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    check(req_ready == 1'b1, "R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
    rd(0, 0, "R1 entry 0 zero");
    rd(255, 3, "R1 entry 255 zero");

    // R3 set, R2 read through other windows
    wr(1, 3, 32'h10);
    rd(3, 2, "R2 read via add window");
    rd(3, 1, "R3 set value");
    // R4 add, R5 subtract to exactly zero
    wr(2, 3, 32'h5);
    rd(3, 0, "R4 add result");
    wr(3, 3, 32'h15);
    rd(3, 3, "R5 subtract to zero");
    drain();
    check(sat_err == exp_err, "R5 exact zero no error", {31'h0, sat_err}, {31'h0, exp_err});
    // R6 store into read window ignored
    wr(1, 4, 32'h77);
    wr(0, 4, 32'h99);
    rd(4, 0, "R6 read window store ignored");

    // R7 completion
    step(0, 0, 0, 0, 0, 1, 7, "");
    step(0, 0, 0, 0, 0, 1, 7, "");
    rd(7, 0, "R7 two completions");
    // R9 different entries same cycle
    step(1, 1, 1, 9, 32'hAB, 1, 8, "");
    rd(8, 0, "R9 completion entry");
    rd(9, 0, "R9 store entry");
    // R8 collisions
    step(1, 1, 1, 10, 32'h20, 1, 10, "");
    rd(10, 0, "R8 set plus completion");
    step(1, 1, 2, 10, 32'h3, 1, 10, "");
    rd(10, 0, "R8 add plus completion");
    step(1, 1, 3, 10, 32'h5, 1, 10, "");
    rd(10, 0, "R8 subtract plus completion");
    step(1, 1, 0, 10, 32'h5, 1, 10, "");
    rd(10, 0, "R8 read-window store plus completion");

    // R11 back-pressure
    drain();
    rsp_ready = 1'b0;
    rd(10, 0, "R11 stalled response data");
    @(negedge clk);
    held = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      check(rsp_valid == 1'b1, "R11 rsp_valid held", {31'h0, rsp_valid}, 32'h1);
      check(req_ready == 1'b0, "R11 req_ready low in stall", {31'h0, req_ready}, 32'h0);
      check(rsp_rdata == held, "R11 rsp_rdata stable", rsp_rdata, held);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    drain();

    // R5 underflow, R10 sticky
    wr(3, 20, 32'h1);
    rd(20, 0, "R5 clamped at zero");
    drain();
    check(sat_err == 1'b1, "R5 underflow sets flag", {31'h0, sat_err}, 32'h1);
    wr(1, 21, 32'h2);
    step(0, 0, 0, 0, 0, 1, 22, "");
    drain();
    check(sat_err == 1'b1, "R10 flag stays set", {31'h0, sat_err}, 32'h1);

    // R4 overflow
    do_reset();
    #1;
    check(sat_err == 1'b0, "R1 flag cleared by reset", {31'h0, sat_err}, 32'h0);
    rd(20, 0, "R1 entry cleared by reset");
    wr(1, 30, 32'hFFFF_FFFE);
    wr(2, 30, 32'h1);
    drain();
    check(sat_err == 1'b0, "R4 exact top no error", {31'h0, sat_err}, 32'h0);
    wr(2, 30, 32'h1);
    rd(30, 0, "R4 clamped at top");
    drain();
    check(sat_err == 1'b1, "R4 overflow sets flag", {31'h0, sat_err}, 32'h1);

    // R7 completion at top
    do_reset();
    wr(1, 40, TOP);
    step(0, 0, 0, 0, 0, 1, 40, "");
    rd(40, 0, "R7 completion clamps");
    drain();
    check(sat_err == 1'b1, "R7 completion overflow flag", {31'h0, sat_err}, 32'h1);

    // R8 collision at top
    do_reset();
    step(1, 1, 1, 41, TOP, 1, 41, "");
    rd(41, 0, "R8 collision clamps");
    drain();
    check(sat_err == 1'b1, "R8 collision overflow flag", {31'h0, sat_err}, 32'h1);

    drain();
    check(exp_q.size() == 0, "R2 all responses seen", exp_q.size(), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule